// File: doc/BRIEF.md
# VBI Slicer Interrupt Controller

This block sits behind a vertical-blanking data slicer. It collects detection events from four groups of sliced data and folds them into one active-high interrupt request. The four groups are closed caption, copy-generation/widescreen signalling, a combined group of guide, programme-delivery, programme-identification and time-code services, and vertical-interval time code. Each group has a sticky status bit. A status bit stays set until host software writes 1 to the matching bit of a self-clearing clear register, or until the group is newly unmasked. The request pin reflects only the groups that are enabled in the mask register.

Closed-caption data gets a one-entry readback buffer. A caption is captured only while the buffer is free. Once captured, the caption stays there until software writes an acknowledge bit. Clearing the caption interrupt does not release the buffer, so interrupt handling and data consumption remain two separate steps.

The combined service group has a mode bit. In one setting it raises an event for every sliced line. In the other it raises an event only when the payload differs from the previous one.

Top module: `vbi_irq_ctrl`

## Requirements
- R1: After synchronous reset, the mask bits, status bits, mode bit, caption-available flag, `irq` and `reg_rdata` are all 0.
- R2: The register addresses are: 0 mask, 1 status, 2 clear, 3 control (bit 0 = change-only mode), 4 caption acknowledge/available (bit 0), 5 caption low byte, 6 caption high byte. The group bits sit at positions 0 (caption), 2 (copy/widescreen), 4 (combined service group) and 6 (time code). The read data for `reg_raddr` appears on `reg_rdata` one clock later. Unused bits, unused addresses and the clear register all read 0.
- R3: An event sets its status bit, and the bit holds until it is cleared. Writing 1 to a clear bit clears that status bit. Writing 0 to a clear bit, or any write to the status address, leaves the status unchanged.
- R4: When an event and a clear of the same status bit occur in the same cycle, the status bit ends up set.
- R5: A status bit records events even while its group is masked. Changing a mask bit from 0 to 1 clears the matching status bit.
- R6: `irq` is high exactly when some status bit and its mask bit are both set. It updates on the same clock edge as the status bits.
- R7: A caption strobe that arrives while the buffer is free stores the caption, sets the available flag and sets caption status.
- R8: While the available flag is set, the stored caption does not change and further caption strobes are dropped, raising no event. Writing 1 to acknowledge bit 0 frees the buffer.
- R9: Clearing the caption status bit leaves both the available flag and the stored caption unchanged.
- R10: With the mode bit at 0, every valid payload of the combined group raises an event. With the mode bit at 1, a valid payload raises an event only if it differs from the last valid payload. The first valid payload after reset always raises an event.
- R11: The copy/widescreen and time-code event strobes set their status bits directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Write address |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | ADDR_W | Read address |
| reg_rdata | output | 8 | Registered read data |
| cc_valid | input | 1 | Caption sliced strobe |
| cc_data | input | CC_W | Caption payload |
| cgms_evt | input | 1 | Copy/widescreen change strobe |
| grp_valid | input | 1 | Combined service group payload strobe |
| grp_data | input | GRP_W | Combined service group payload |
| vitc_evt | input | 1 | Time-code detection strobe |
| irq | output | 1 | Active-high interrupt request |

## Verification
The collision that matters is a detection event landing in the same cycle as a host write that clears the same status bit. The bench drives the copy/widescreen strobe and a clear write on one shared clock edge, then requires that both the status readback and `irq` remain set. The second collision involves the caption path. Once the buffer is full, another caption strobe meets a pending buffer and must be dropped. A status clear must also leave the buffer untouched. The bench judges both cases from the available flag and the readback bytes before and after the acknowledge. Finally, an exhaustive sweep over all mask and event patterns checks `irq` and the status readback against values derived from the bit map.

// File: rtl/vbi_irq_pkg.sv
package vbi_irq_pkg;
  localparam int NSRC     = 4;
  localparam int SRC_CAP  = 0;
  localparam int SRC_CGMS = 1;
  localparam int SRC_GRP  = 2;
  localparam int SRC_VITC = 3;

  localparam int RA_MASK  = 0;
  localparam int RA_STAT  = 1;
  localparam int RA_CLR   = 2;
  localparam int RA_CTRL  = 3;
  localparam int RA_CAP   = 4;
  localparam int RA_CAPLO = 5;
  localparam int RA_CAPHI = 6;

  // source i lives at byte bit 2*i
  function automatic logic [7:0] spread(input logic [NSRC-1:0] s);
    logic [7:0] b;
    b = '0;
    for (int i = 0; i < NSRC; i++) b[2*i] = s[i];
    return b;
  endfunction

  function automatic logic [NSRC-1:0] gather(input logic [7:0] b);
    logic [NSRC-1:0] s;
    for (int i = 0; i < NSRC; i++) s[i] = b[2*i];
    return s;
  endfunction
endpackage

// File: rtl/vbi_irq_core.sv
module vbi_irq_core #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wr,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_bits,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] status_q,
  output logic            irq
);
  logic [NSRC-1:0] mask_d, status_d, mask_rise, clr_hit;

  assign mask_d = mask_we ? mask_wr : mask_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign mask_rise[i] = mask_we & mask_wr[i] & ~mask_q[i];
    assign clr_hit[i]   = clr_we & clr_bits[i];
    // event has priority over clear and over unmask
    assign status_d[i]  = evt[i] | (status_q[i] & ~clr_hit[i] & ~mask_rise[i]);

    a_r4_event_wins: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> status_q[i]);
    a_r3_clear_works: assert property (@(posedge clk) disable iff (rst)
      clr_hit[i] && !evt[i] |=> !status_q[i]);
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
      status_q[i] && !clr_hit[i] && !mask_rise[i] |=> status_q[i]);
    a_r5_unmask_clears: assert property (@(posedge clk) disable iff (rst)
      mask_rise[i] && !evt[i] |=> !status_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      status_q <= '0;
      irq      <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      status_q <= status_d;
      irq      <= |(status_d & mask_d);
    end
  end

  a_r6_irq_has_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> |(status_q & mask_q));
endmodule

// File: rtl/vbi_cap_buffer.sv
module vbi_cap_buffer #(
  parameter int CC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cc_valid,
  input  logic [CC_W-1:0] cc_data,
  input  logic            ack,
  output logic            avail_q,
  output logic [CC_W-1:0] data_q,
  output logic            evt
);
  logic take;

  assign take = cc_valid & ~avail_q;
  assign evt  = take;

  always_ff @(posedge clk) begin
    if (rst) begin
      avail_q <= 1'b0;
      data_q  <= '0;
    end else if (take) begin
      avail_q <= 1'b1;
      data_q  <= cc_data;
    end else if (ack) begin
      avail_q <= 1'b0;
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    avail_q && !ack |=> avail_q && $stable(data_q));
  a_r7_capture: assert property (@(posedge clk) disable iff (rst)
    cc_valid && !avail_q |=> avail_q && data_q == $past(cc_data));
endmodule

// File: rtl/vbi_grp_change.sv
module vbi_grp_change #(
  parameter int GRP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grp_valid,
  input  logic [GRP_W-1:0] grp_data,
  input  logic             change_only,
  output logic             evt
);
  logic [GRP_W-1:0] last_q;
  logic             seen_q;
  logic             differs;

  assign differs = ~seen_q | (grp_data != last_q);
  assign evt     = grp_valid & (~change_only | differs);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '0;
      seen_q <= 1'b0;
    end else if (grp_valid) begin
      last_q <= grp_data;
      seen_q <= 1'b1;
    end
  end

  a_r10_repeat_quiet: assert property (@(posedge clk) disable iff (rst)
    grp_valid && change_only && seen_q && grp_data == last_q |-> !evt);
  a_r10_first_counts: assert property (@(posedge clk) disable iff (rst)
    grp_valid && !seen_q |-> evt);
endmodule

// File: rtl/vbi_irq_ctrl.sv
module vbi_irq_ctrl
  import vbi_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CC_W   = 16,
  parameter int GRP_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [7:0]        reg_rdata,
  input  logic              cc_valid,
  input  logic [CC_W-1:0]   cc_data,
  input  logic              cgms_evt,
  input  logic              grp_valid,
  input  logic [GRP_W-1:0]  grp_data,
  input  logic              vitc_evt,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(RA_MASK);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(RA_STAT);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(RA_CLR);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(RA_CTRL);
  localparam logic [ADDR_W-1:0] A_CAP   = ADDR_W'(RA_CAP);
  localparam logic [ADDR_W-1:0] A_CAPLO = ADDR_W'(RA_CAPLO);
  localparam logic [ADDR_W-1:0] A_CAPHI = ADDR_W'(RA_CAPHI);

  logic            mode_q;
  logic            cap_ack, cap_avail, cap_evt, grp_evt;
  logic [CC_W-1:0] cap_data;
  logic [15:0]     cap_ext;
  logic [NSRC-1:0] evt, mask_q, status_q;
  logic            mask_we, clr_we;

  assign mask_we = reg_we && reg_addr == A_MASK;
  assign clr_we  = reg_we && reg_addr == A_CLR;
  assign cap_ack = reg_we && reg_addr == A_CAP && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst)                              mode_q <= 1'b0;
    else if (reg_we && reg_addr == A_CTRL) mode_q <= reg_wdata[0];
  end

  vbi_cap_buffer #(.CC_W(CC_W)) u_cap (
    .clk(clk), .rst(rst), .cc_valid(cc_valid), .cc_data(cc_data),
    .ack(cap_ack), .avail_q(cap_avail), .data_q(cap_data), .evt(cap_evt)
  );

  vbi_grp_change #(.GRP_W(GRP_W)) u_grp (
    .clk(clk), .rst(rst), .grp_valid(grp_valid), .grp_data(grp_data),
    .change_only(mode_q), .evt(grp_evt)
  );

  always_comb begin
    evt           = '0;
    evt[SRC_CAP]  = cap_evt;
    evt[SRC_CGMS] = cgms_evt;
    evt[SRC_GRP]  = grp_evt;
    evt[SRC_VITC] = vitc_evt;
  end

  vbi_irq_core #(.NSRC(NSRC)) u_core (
    .clk(clk), .rst(rst), .evt(evt),
    .mask_we(mask_we), .mask_wr(gather(reg_wdata)),
    .clr_we(clr_we), .clr_bits(gather(reg_wdata)),
    .mask_q(mask_q), .status_q(status_q), .irq(irq)
  );

  assign cap_ext = 16'(cap_data);

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      unique case (reg_raddr)
        A_MASK:  reg_rdata <= spread(mask_q);
        A_STAT:  reg_rdata <= spread(status_q);
        A_CTRL:  reg_rdata <= {7'b0, mode_q};
        A_CAP:   reg_rdata <= {7'b0, cap_avail};
        A_CAPLO: reg_rdata <= cap_ext[7:0];
        A_CAPHI: reg_rdata <= cap_ext[15:8];
        default: reg_rdata <= '0;
      endcase
    end
  end

  a_r9_clear_keeps_buffer: assert property (@(posedge clk) disable iff (rst)
    clr_we && !cap_ack && cap_avail |=> cap_avail);
endmodule

// File: tb/vbi_irq_ctrl_tb.sv
module vbi_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [2:0]  reg_raddr = '0;
  logic [7:0]  reg_rdata;
  logic        cc_valid = 1'b0;
  logic [15:0] cc_data = '0;
  logic        cgms_evt = 1'b0;
  logic        grp_valid = 1'b0;
  logic [15:0] grp_data = '0;
  logic        vitc_evt = 1'b0;
  logic        irq;

  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vbi_irq_ctrl u_dut (.*);

  function automatic logic [7:0] sp(input logic [3:0] s);
    return {1'b0, s[3], 1'b0, s[2], 1'b0, s[1], 1'b0, s[0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a[2:0]; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    reg_raddr = a[2:0];
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic fire(input logic [3:0] s, input logic [15:0] cd, input logic [15:0] gd);
    cc_valid = s[0]; cc_data = cd; cgms_evt = s[1];
    grp_valid = s[2]; grp_data = gd; vitc_evt = s[3];
    @(negedge clk);
    cc_valid = 0; cgms_evt = 0; grp_valid = 0; vitc_evt = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", irq, 0);
    rd(0, v); chk("R1 mask", v, 0);
    rd(1, v); chk("R1 status", v, 0);
    rd(3, v); chk("R1 mode", v, 0);
    rd(4, v); chk("R1 avail", v, 0);

    // R10 change-only mode from reset: first payload counts
    wr(3, 8'h01);
    rd(3, v); chk("R2 ctrl readback", v, 8'h01);
    fire(4'b0100, 0, 16'h00A5);
    rd(1, v); chk("R10 first payload event", v, 8'h10);
    wr(2, 8'h10);
    fire(4'b0100, 0, 16'h00A5);
    rd(1, v); chk("R10 repeat no event", v, 8'h00);
    fire(4'b0100, 0, 16'h00A6);
    rd(1, v); chk("R10 changed payload event", v, 8'h10);
    wr(2, 8'h10);
    wr(3, 8'h00);
    fire(4'b0100, 0, 16'h00A6);
    rd(1, v); chk("R10 every-line mode", v, 8'h10);
    wr(2, 8'h10);

    // R2 unused addresses / bits, clear reads 0
    wr(0, 8'hFF);
    rd(0, v); chk("R2 unused mask bits", v, 8'h55);
    rd(2, v); chk("R2 clear reads 0", v, 0);
    rd(7, v); chk("R2 unused addr", v, 0);

    // R11 + R3: direct strobes, clear with 0 no effect, status write ignored
    fire(4'b1010, 0, 0);
    chk("R6 irq on strobe", irq, 1);
    rd(1, v); chk("R11 direct strobes", v, 8'h44);
    wr(2, 8'h00);
    wr(1, 8'h00);
    rd(1, v); chk("R3 zero clear/status write no effect", v, 8'h44);
    wr(2, 8'h40);
    rd(1, v); chk("R3 partial clear", v, 8'h04);
    // R4 event and clear on same edge
    cgms_evt = 1; reg_we = 1; reg_addr = 3'd2; reg_wdata = 8'h04;
    @(negedge clk);
    cgms_evt = 0; reg_we = 0;
    chk("R4 irq stays", irq, 1);
    rd(1, v); chk("R4 event wins", v, 8'h04);
    wr(2, 8'h04);
    chk("R6 irq drops", irq, 0);

    // R5 records while masked, unmask clears
    wr(0, 8'h00);
    fire(4'b1000, 0, 0);
    chk("R5 masked no irq", irq, 0);
    rd(1, v); chk("R5 records while masked", v, 8'h40);
    wr(0, 8'h40);
    rd(1, v); chk("R5 unmask clears", v, 8'h00);
    chk("R5 irq after unmask", irq, 0);
    wr(0, 8'h00);

    // R7 R8 R9 caption buffer
    fire(4'b0001, 16'h1234, 0);
    rd(4, v); chk("R7 avail set", v, 1);
    rd(1, v); chk("R7 caption status", v, 8'h01);
    wr(2, 8'h01);
    fire(4'b0001, 16'hABCD, 0);
    rd(1, v); chk("R8 dropped caption no event", v, 0);
    rd(5, v); chk("R8 low byte held", v, 8'h34);
    rd(6, v); chk("R8 high byte held", v, 8'h12);
    wr(2, 8'h01);
    rd(4, v); chk("R9 avail survives clear", v, 1);
    rd(5, v); chk("R9 data survives clear", v, 8'h34);
    wr(4, 8'h01);
    rd(4, v); chk("R8 ack frees", v, 0);
    fire(4'b0001, 16'hABCD, 0);
    rd(5, v); chk("R8 new caption low", v, 8'hCD);
    rd(6, v); chk("R8 new caption high", v, 8'hAB);
    wr(4, 8'h01);
    wr(2, 8'h55);

    // R6 exhaustive mask x event sweep
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        wr(0, sp(m[3:0]));
        fire(p[3:0], 16'(p), 16'(p));
        chk("R6 sweep irq", irq, |(m[3:0] & p[3:0]));
        rd(1, v); chk("R3 sweep status", v, sp(p[3:0]));
        wr(2, 8'h55);
        wr(4, 8'h01);
        wr(0, 8'h00);
        chk("R6 sweep irq clear", irq, 0);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule